// File: doc/BRIEF.md
# Pipelined Eleven-Way Bus Selector

This block chooses one of eleven 8-bit input lanes and presents it on an 8-bit output, with every path running through registers clocked on the rising edge. The lane is picked by a 4-bit code that counts from one: code 1 names the first lane and code 11 names the eleventh. Codes 0 and 12 to 15 are not valid lane numbers, and for those codes the first lane is used.

The result reaches the output two clock cycles after the code and the lanes are sampled. The first register holds the chosen lane. The second register only moves that value to the output, so the decode and the eleven-input AND-OR tree take one full cycle, and the output pin is driven straight from a flop. A new code and set of lanes may be applied on every cycle, and one result comes out per clock. The lanes arrive as one flat vector. Lane k (counting from 1) sits in bits [(k-1)*8 +: 8].

The block has no state machine. Its behaviour is fixed by the two pipeline stages: the capture stage (`stage_a`) and the output stage (`stage_b`). A synchronous reset clears both stages.

Top module: `bus_sel11_pipe`

## Requirements
- R1: A code k from 1 to 11 places lane k, held in bits [(k-1)*8 +: 8] of `lanes_i`, on `data_o`.
- R2: Codes 0, 12, 13, 14 and 15 place lane 1 (bits [7:0]) on `data_o`.
- R3: The latency is exactly two rising edges. The inputs sampled at edge n appear on `data_o` after edge n+1 and not after edge n.
- R4: Codes and lanes may change on every cycle. Each sampled pair yields its own result, in order, with no cycle skipped.
- R5: When `rst_i` is high at a rising edge, both stages load zero. `data_o` reads 0 after that edge and stays 0 for the first edge after reset is released.
- R6: A change on `lanes_i` or `code_i` between clock edges has no effect on `data_o` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. All state changes on the rising edge. |
| rst_i | input | 1 | Synchronous reset, active high. Clears both stages. |
| lanes_i | input | 88 | Eleven 8-bit lanes. Lane k is in bits [(k-1)*8 +: 8]. |
| code_i | input | 4 | Lane select code. 1 to 11 pick a lane; any other value picks lane 1. |
| data_o | output | 8 | Selected lane, delayed by two cycles. |

## Verification
The assertions run on every cycle once two edges have passed since reset. They compare `data_o` with the lane that the code chose two edges earlier, one property per code from 1 to 11 and one for the fallback codes. They also check that the decoder output is one-hot, and that both stages read zero at the first edge after reset is released. Only the bench scenarios can show the points that no local property can express:
- there is no path from input to output between edges;
- the latency is exactly two edges and not more;
- back-to-back streams and a reset in the middle of a stream line up correctly with the pipeline.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    localparam int BUS_COUNT = 11;
    localparam int BUS_W     = 8;
    localparam int CODE_W    = 4;
endpackage

// File: rtl/bsel_code_decode.sv
// Turns the one-based select code into a one-hot lane enable.
// Codes outside 1..N enable lane 0 (R2).
module bsel_code_decode #(
    parameter int N  = 11,
    parameter int CW = 4
) (
    input  logic [CW-1:0] code_i,
    output logic [N-1:0]  hot_o
);
    always_comb begin
        hot_o = '0;
        if (code_i != '0 && int'(code_i) <= N) begin
            hot_o[code_i - CW'(1)] = 1'b1;   // R1: code k picks lane k
        end else begin
            hot_o[0] = 1'b1;                 // R2: fallback to lane 1
        end
    end
endmodule

// File: rtl/bsel_andor.sv
// Eleven-input selector built as AND masks followed by an OR reduction.
module bsel_andor #(
    parameter int N = 11,
    parameter int W = 8
) (
    input  logic [N*W-1:0] lanes_i,
    input  logic [N-1:0]   hot_i,
    output logic [W-1:0]   pick_o
);
    logic [W-1:0] masked [N];

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign masked[i] = lanes_i[i*W +: W] & {W{hot_i[i]}};
    end

    always_comb begin
        pick_o = '0;
        for (int i = 0; i < N; i++) begin
            pick_o = pick_o | masked[i];
        end
    end
endmodule

// File: rtl/bsel_stage.sv
// One pipeline register with synchronous active-high clear.
module bsel_stage #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/bus_sel11_pipe.sv
module bus_sel11_pipe
    import bsel_pkg::*;
#(
    parameter int N  = BUS_COUNT,
    parameter int W  = BUS_W,
    parameter int CW = CODE_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [N*W-1:0] lanes_i,
    input  logic [CW-1:0] code_i,
    output logic [W-1:0]  data_o
);
    logic [N-1:0] hot;
    logic [W-1:0] picked;
    logic [W-1:0] stage_a_q;

    bsel_code_decode #(.N(N), .CW(CW)) u_dec (
        .code_i (code_i),
        .hot_o  (hot)
    );

    bsel_andor #(.N(N), .W(W)) u_mux (
        .lanes_i (lanes_i),
        .hot_i   (hot),
        .pick_o  (picked)
    );

    // capture stage: first of the two latency registers (R3)
    bsel_stage #(.W(W)) u_stage_a (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (picked),
        .q_o   (stage_a_q)
    );

    // output stage: drives the pin straight from a flop (R3, R6)
    bsel_stage #(.W(W)) u_stage_b (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (stage_a_q),
        .q_o   (data_o)
    );

    // ---------------- assertions ----------------
    // Counts non-reset edges since reset, saturating at 2, so that
    // $past(...,2) only looks at cycles after reset.
    logic [1:0] warm_cnt;
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            warm_cnt <= 2'd0;
        end else if (warm_cnt != 2'd2) begin
            warm_cnt <= warm_cnt + 2'd1;
        end
    end
    logic warm;
    assign warm = (warm_cnt == 2'd2);

    a_r1_onehot_enable: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(hot));

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r1_lane_pick: assert property (@(posedge clk_i) disable iff (rst_i)
            (warm && $past(code_i, 2) == CW'(k + 1))
            |-> data_o == $past(lanes_i[k*W +: W], 2));
    end

    a_r2_fallback_lane: assert property (@(posedge clk_i) disable iff (rst_i)
        (warm && ($past(code_i, 2) == '0 || $past(code_i, 2) > CW'(N)))
        |-> data_o == $past(lanes_i[W-1:0], 2));

    a_r5_cleared_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (data_o == '0 && stage_a_q == '0));
endmodule

// File: tb/bus_sel11_pipe_test.sv
module bus_sel11_pipe_test;
    localparam int N  = 11;
    localparam int W  = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N*W-1:0] lanes = '0;
    logic [CW-1:0] code = '0;
    logic [W-1:0]  dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_sel11_pipe uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .lanes_i (lanes),
        .code_i  (code),
        .data_o  (dout)
    );

    // Expected value for the inputs currently applied, plus its requirement tag.
    logic [W-1:0] cur_exp = '0;
    int           cur_tag = 5;
    // Scoreboard queue: [0] = stage one model, [1] = output model, [2] = older.
    logic [W-1:0] q_val [3];
    int           q_tag [3];

    function automatic logic [W-1:0] model(input logic [CW-1:0] c,
                                           input logic [N*W-1:0] l);
        int idx;
        idx = (c >= 1 && c <= 11) ? int'(c) - 1 : 0;   // R1 / R2 rule
        return l[idx*W +: W];
    endfunction

    task automatic check(input int req, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%02h expected=%02h at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // driver: applies one pair at the falling edge and records its expectation
    task automatic drive(input logic [CW-1:0] c, input logic [N*W-1:0] l,
                         input logic r, input int tag);
        @(negedge clk);
        code    = c;
        lanes   = l;
        rst     = r;
        cur_exp = r ? '0 : model(c, l);
        cur_tag = r ? 5 : tag;
    endtask

    function automatic logic [N*W-1:0] marked_lanes(input logic [7:0] salt);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = 8'(((i + 1) << 4) | (i + 1)) ^ salt;
        return v;
    endfunction

    // monitor: pops the entry from two edges back and compares
    logic         mon_on = 1'b0;
    logic [W-1:0] snap;
    always @(posedge clk) begin
        #2;
        if (rst) begin
            q_val[2] = q_val[1]; q_tag[2] = q_tag[1];
            q_val[1] = '0;       q_tag[1] = 5;   // R5: both stages cleared
            q_val[0] = '0;       q_tag[0] = 5;
        end else begin
            q_val[2] = q_val[1]; q_tag[2] = q_tag[1];
            q_val[1] = q_val[0]; q_tag[1] = q_tag[0];
            q_val[0] = cur_exp;  q_tag[0] = cur_tag;
        end
        if (mon_on && !done) begin
            check(q_tag[1], dout, q_val[1], "two-cycle result");
            snap = dout;
            #5;   // inputs changed at the falling edge in between
            check(6, dout, snap, "held between edges (R6)");
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] l;
        @(posedge clk);
        mon_on = 1'b1;   // R5: output must read 0 after the first reset edge
        repeat (2) drive('0, '0, 1'b1, 5);

        // R1: every valid code with distinguishable lanes
        for (int k = 1; k <= 11; k++) drive(CW'(k), marked_lanes(8'h00), 1'b0, 1);
        for (int k = 11; k >= 1; k--) drive(CW'(k), marked_lanes(8'hA5), 1'b0, 1);

        // R2: fallback codes
        drive(4'd0, marked_lanes(8'h3C), 1'b0, 2);
        for (int k = 12; k <= 15; k++) drive(CW'(k), marked_lanes(8'h5A), 1'b0, 2);

        // R3: a lone change; the old value must persist for one more edge
        drive(4'd7, marked_lanes(8'h00), 1'b0, 3);
        drive(4'd7, marked_lanes(8'h00), 1'b0, 3);
        drive(4'd9, marked_lanes(8'hFF), 1'b0, 3);
        drive(4'd9, marked_lanes(8'hFF), 1'b0, 3);
        drive(4'd9, marked_lanes(8'hFF), 1'b0, 3);

        // R4: back-to-back random stream, a new pair each cycle
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < N; i++) l[i*W +: W] = 8'($urandom);
            drive(CW'($urandom), l, 1'b0, 4);
        end

        // R5: reset in the middle of a stream
        drive(4'd3, marked_lanes(8'h11), 1'b0, 4);
        drive(4'd5, marked_lanes(8'h22), 1'b0, 4);
        drive(4'd6, marked_lanes(8'h33), 1'b1, 5);
        drive(4'd6, marked_lanes(8'h33), 1'b0, 1);
        drive(4'd2, marked_lanes(8'h44), 1'b0, 1);
        repeat (4) drive(4'd11, marked_lanes(8'h55), 1'b0, 1);

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule